// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-side front end of a small SCSI protocol controller. The host sees two byte-wide locations inside an eight-byte window. The first is an address/status port at byte offset 3. The second is a data port at byte offset 7, four bytes further on. A write to the address port chooses one of 32 internal byte registers. A read of the address port returns an auxiliary status byte. Reads and writes on the data port reach whichever register is currently chosen.

The block holds the register bank, the select pointer and a pending-interrupt flag, and it drives the flag out as a level interrupt. Command execution belongs to a separate sequencer. Every landed data-port write is reported to that sequencer as a one-cycle strobe carrying the register index written. The sequencer reports an event back with a raise pulse and a new status-register value.

Host accesses are single-cycle synchronous strobes. Read data appears on the cycle after the read strobe and holds until the next read. After each data-port write the select pointer steps forward by one. A read does not move the pointer. Reading the status register through the data port acknowledges the interrupt.

Top module: `host_reg_port`

## Requirements
- R1: Only byte offsets 3 (address port) and 7 (data port) are decoded. An access to any other offset changes no register, no pointer and no flag, and a read there returns 0x00.
- R2: A read of offset 3 returns an auxiliary status byte. Bit 0 is always 1, bit 7 equals the pending-interrupt flag, and every other bit is 0.
- R3: A write to offset 3 loads the select pointer with the low 5 bits of the written byte, so the value is taken modulo 32.
- R4: A write to offset 7 stores the byte into the selected register and then advances the select pointer by one. The pointer wraps from 31 to 0.
- R5: A read of offset 7 returns the selected register and leaves the select pointer unchanged.
- R6: A read of offset 7 while the pointer selects register 23 (the command status register) clears the pending flag.
- R7: A write to offset 7 while the pointer selects register 1 (the control register) clears the pending flag when bit 3 of the written byte is 1. When bit 3 is 0 the flag is left unchanged.
- R8: A raise pulse from the sequencer sets the pending flag and loads register 23 with the supplied value. A raise wins over a clear in the same cycle, and it also wins over a host write to register 23 in the same cycle.
- R9: The interrupt output is a level equal to the pending flag, updated on the clock edge that ends each access.
- R10: One cycle after every data-port write, the command strobe is high for exactly one cycle and the command index equals the register that was written.
- R11: Reset clears the select pointer, all 32 registers, the pending flag, the read data and the command outputs.
- R12: Read data updates on the cycle after a read strobe and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Host access strobe, one cycle per access |
| accWr | input | 1 | 1 = write access, 0 = read access |
| accOfs | input | 3 | Byte offset within the device window |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Host read byte, valid the cycle after a read |
| irq | output | 1 | Level interrupt, follows the pending flag |
| seqRaise | input | 1 | Sequencer event: set pending and load the status register |
| seqCsrValue | input | 8 | Status value loaded on seqRaise |
| cmdStrobe | output | 1 | One-cycle pulse after each data-port write |
| cmdIndex | output | 5 | Register index of that write |

## Verification
The bench builds the block with its default parameters: 32 registers, an eight-byte window, the status register at index 23, the control register at index 1 and the acknowledge bit at bit 3. With a 5-bit pointer, a few hundred random accesses already walk the pointer through its 31-to-0 wrap many times. They also land data-port accesses on the status and control registers often enough that both clear paths collide with sequencer raises. Directed sequences pin down masking of an oversized address byte, the wrap itself, and raise-over-clear priority.

// File: rtl/host_reg_port_pkg.sv
package host_reg_port_pkg;
  // One-hot decoded access kind handed from control to datapath.
  typedef struct packed {
    logic selLoad;  // address-port write
    logic dataWr;   // data-port write
    logic dataRd;   // data-port read
    logic auxRd;    // address-port read (auxiliary status)
    logic nullRd;   // read of an undecoded offset
  } portStrobe_t;
endpackage

// File: rtl/host_reg_port_ctrl.sv
module host_reg_port_ctrl
  import host_reg_port_pkg::*;
#(
  parameter int OFS_W       = 3,
  parameter int ADDR_OFS    = 3,
  parameter int PORT_STRIDE = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accEn,
  input  logic             accWr,
  input  logic [OFS_W-1:0] accOfs,
  output portStrobe_t      strobe
);
  localparam logic [OFS_W-1:0] ADDR_PORT = OFS_W'(ADDR_OFS);
  localparam logic [OFS_W-1:0] DATA_PORT = OFS_W'(ADDR_OFS + PORT_STRIDE);

  logic hitAddr;
  logic hitData;

  always_comb begin
    hitAddr = (accOfs == ADDR_PORT);
    hitData = (accOfs == DATA_PORT);
    strobe = '0;
    if (accEn) begin
      strobe.selLoad = accWr && hitAddr;
      strobe.dataWr  = accWr && hitData;
      strobe.auxRd   = !accWr && hitAddr;
      strobe.dataRd  = !accWr && hitData;
      strobe.nullRd  = !accWr && !hitAddr && !hitData;
    end
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)) else $error("more than one access kind");  // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |-> (strobe == '0)) else $error("strobe without access");  // R1
endmodule

// File: rtl/host_reg_port_dp.sv
module host_reg_port_dp
  import host_reg_port_pkg::*;
#(
  parameter int NREG        = 32,
  parameter int DW          = 8,
  parameter int CSR_IDX     = 23,
  parameter int CTRL_IDX    = 1,
  parameter int EDI_BIT     = 3,
  parameter int AUX_INT_BIT = 7,
  parameter int AUX_DBR_BIT = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  portStrobe_t             strobe,
  input  logic [DW-1:0]           wrData,
  input  logic                    seqRaise,
  input  logic [DW-1:0]           seqCsrValue,
  output logic [DW-1:0]           rdData,
  output logic                    irq,
  output logic                    cmdStrobe,
  output logic [$clog2(NREG)-1:0] cmdIndex
);
  localparam int PTR_W = $clog2(NREG);
  localparam logic [PTR_W-1:0] CSR_SEL  = PTR_W'(CSR_IDX);
  localparam logic [PTR_W-1:0] CTRL_SEL = PTR_W'(CTRL_IDX);

  logic [DW-1:0]    bank [NREG];
  logic [PTR_W-1:0] selPtr;
  logic             pending;
  logic [DW-1:0]    auxVal;
  logic             clrHit;

  always_comb begin
    auxVal = '0;
    auxVal[AUX_DBR_BIT] = 1'b1;
    auxVal[AUX_INT_BIT] = pending;
    clrHit = (strobe.dataRd && selPtr == CSR_SEL)
          || (strobe.dataWr && selPtr == CTRL_SEL && wrData[EDI_BIT]);
  end

  // Register bank: host byte writes, sequencer status loads win on collision.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else begin
      if (strobe.dataWr) bank[selPtr] <= wrData;
      if (seqRaise)      bank[CSR_SEL] <= seqCsrValue;
    end
  end

  // Select pointer, pending flag, read data and command report.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selPtr    <= '0;
      pending   <= 1'b0;
      rdData    <= '0;
      cmdStrobe <= 1'b0;
      cmdIndex  <= '0;
    end else begin
      if (strobe.selLoad)     selPtr <= wrData[PTR_W-1:0];
      else if (strobe.dataWr) selPtr <= selPtr + 1'b1;

      if (seqRaise)    pending <= 1'b1;
      else if (clrHit) pending <= 1'b0;

      if (strobe.auxRd)       rdData <= auxVal;
      else if (strobe.dataRd) rdData <= bank[selPtr];
      else if (strobe.nullRd) rdData <= '0;

      cmdStrobe <= strobe.dataWr;
      if (strobe.dataWr) cmdIndex <= selPtr;
    end
  end

  assign irq = pending;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataWr |=> selPtr == $past(selPtr) + 1'b1) else $error("ptr step");  // R4
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selLoad |=> selPtr == $past(wrData[PTR_W-1:0])) else $error("ptr load");  // R3
  AST_RD_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRd || strobe.auxRd || strobe.nullRd) |=> $stable(selPtr)) else $error("ptr moved");  // R5
  AST_CSR_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dataRd && selPtr == CSR_SEL && !seqRaise) |=> !irq) else $error("csr ack");  // R6
  AST_RAISE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    seqRaise |=> irq && bank[CSR_SEL] == $past(seqCsrValue)) else $error("raise");  // R8
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dataWr |=> cmdStrobe && cmdIndex == $past(selPtr)) else $error("cmd pulse");  // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.dataRd || strobe.auxRd || strobe.nullRd) |=> $stable(rdData)) else $error("rd hold");  // R12
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import host_reg_port_pkg::*;
#(
  parameter int NREG        = 32,
  parameter int DW          = 8,
  parameter int OFS_W       = 3,
  parameter int ADDR_OFS    = 3,
  parameter int PORT_STRIDE = 4,
  parameter int CSR_IDX     = 23,
  parameter int CTRL_IDX    = 1,
  parameter int EDI_BIT     = 3,
  parameter int AUX_INT_BIT = 7,
  parameter int AUX_DBR_BIT = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    accEn,
  input  logic                    accWr,
  input  logic [OFS_W-1:0]        accOfs,
  input  logic [DW-1:0]           wrData,
  output logic [DW-1:0]           rdData,
  output logic                    irq,
  input  logic                    seqRaise,
  input  logic [DW-1:0]           seqCsrValue,
  output logic                    cmdStrobe,
  output logic [$clog2(NREG)-1:0] cmdIndex
);
  portStrobe_t strobe;

  host_reg_port_ctrl #(
    .OFS_W(OFS_W), .ADDR_OFS(ADDR_OFS), .PORT_STRIDE(PORT_STRIDE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr),
    .accOfs(accOfs), .strobe(strobe)
  );

  host_reg_port_dp #(
    .NREG(NREG), .DW(DW), .CSR_IDX(CSR_IDX), .CTRL_IDX(CTRL_IDX),
    .EDI_BIT(EDI_BIT), .AUX_INT_BIT(AUX_INT_BIT), .AUX_DBR_BIT(AUX_DBR_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .seqRaise(seqRaise), .seqCsrValue(seqCsrValue), .rdData(rdData),
    .irq(irq), .cmdStrobe(cmdStrobe), .cmdIndex(cmdIndex)
  );
endmodule

// File: tb/sim_host_reg_port.sv
`timescale 1ns/1ps
module sim_host_reg_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accEn = 1'b0;
  logic       accWr = 1'b0;
  logic [2:0] accOfs = '0;
  logic [7:0] wrData = '0;
  logic       seqRaise = 1'b0;
  logic [7:0] seqCsrValue = '0;
  logic [7:0] rdData;
  logic       irq;
  logic       cmdStrobe;
  logic [4:0] cmdIndex;

  int compared = 0;
  int mismatched = 0;

  // Bench model of the block
  logic [7:0] mBank [32];
  logic [4:0] mPtr;
  logic       mPend;
  logic [7:0] mRd;

  always #2.5 clk = ~clk;

  host_reg_port u0 (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWr(accWr), .accOfs(accOfs),
    .wrData(wrData), .rdData(rdData), .irq(irq), .seqRaise(seqRaise),
    .seqCsrValue(seqCsrValue), .cmdStrobe(cmdStrobe), .cmdIndex(cmdIndex)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] auxExp(input logic pend);
    return {pend, 6'b0, 1'b1};
  endfunction

  // One access (optionally with a sequencer raise), then check all outputs.
  task automatic doOp(input bit en, input bit wr, input logic [2:0] ofs,
                      input logic [7:0] d, input bit raise, input logic [7:0] rv);
    logic [4:0] prePtr;
    bit clr;
    bit isDataWr;
    string rdTag;
    @(negedge clk);
    accEn = en; accWr = wr; accOfs = ofs; wrData = d;
    seqRaise = raise; seqCsrValue = rv;
    prePtr = mPtr; clr = 0; isDataWr = 0; rdTag = "R12";
    if (en && wr && ofs == 3'd3) mPtr = d[4:0];
    else if (en && wr && ofs == 3'd7) begin
      mBank[prePtr] = d; mPtr = prePtr + 1'b1; isDataWr = 1;
      if (prePtr == 5'd1 && d[3]) clr = 1;
    end else if (en && !wr && ofs == 3'd3) begin
      mRd = auxExp(mPend); rdTag = "R2";
    end else if (en && !wr && ofs == 3'd7) begin
      mRd = mBank[prePtr]; rdTag = "R5";
      if (prePtr == 5'd23) clr = 1;
    end else if (en && !wr) begin
      mRd = 8'h00; rdTag = "R1";
    end
    if (raise) begin mBank[23] = rv; mPend = 1; end
    else if (clr) mPend = 0;
    @(negedge clk);
    accEn = 0; seqRaise = 0;
    check(rdTag, rdData, mRd);
    check("R9", irq, mPend);
    check("R10", cmdStrobe, isDataWr);
    if (isDataWr) check("R10", cmdIndex, prePtr);
  endtask

  task automatic wrAddr(input logic [7:0] v); doOp(1, 1, 3'd3, v, 0, 0); endtask
  task automatic wrDat(input logic [7:0] v);  doOp(1, 1, 3'd7, v, 0, 0); endtask
  task automatic rdDat();                     doOp(1, 0, 3'd7, 0, 0, 0); endtask
  task automatic rdAux();                     doOp(1, 0, 3'd3, 0, 0, 0); endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mBank[i] = 8'h00;
    mPtr = 0; mPend = 0; mRd = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11", rdData, 0);
    check("R11", irq, 0);
    check("R11", cmdStrobe, 0);
    rdAux();                     // R2 with no pending -> 0x01
    check("R2", rdData, 8'h01);
    rdDat();                     // R11 register 0 cleared
    check("R11", rdData, 8'h00);

    // R3: oversized address byte masked to 5 bits
    wrAddr(8'hFF); wrDat(8'hA5); // lands in reg 31, pointer wraps to 0
    wrDat(8'h5A);                // R4 wrap: lands in reg 0
    wrAddr(8'h3F); rdDat(); check("R3", rdData, 8'hA5);
    rdDat(); check("R5", rdData, 8'hA5); // pointer did not move
    wrAddr(8'h00); rdDat(); check("R4", rdData, 8'h5A);

    // R8 / R6: raise then acknowledge via status read
    doOp(0, 0, 3'd0, 0, 1, 8'h42);
    check("R8", irq, 1);
    rdAux(); check("R2", rdData, 8'h81);
    wrAddr(8'd23); rdDat();
    check("R6", rdData, 8'h42); check("R6", irq, 0);

    // R7: control write without bit 3 keeps pending, with bit 3 clears
    doOp(0, 0, 3'd0, 0, 1, 8'h16);
    wrAddr(8'd1); wrDat(8'hF7); check("R7", irq, 1);
    wrAddr(8'd1); wrDat(8'h08); check("R7", irq, 0);

    // R8: raise collides with status read clear and host write to reg 23
    wrAddr(8'd23); doOp(1, 0, 3'd7, 0, 1, 8'h99);
    check("R8", irq, 1);
    wrAddr(8'd23); doOp(1, 1, 3'd7, 8'h11, 1, 8'h77);
    wrAddr(8'd23); rdDat(); check("R8", rdData, 8'h77);

    // R1: undecoded offsets ignored
    wrAddr(8'd5); doOp(1, 1, 3'd2, 8'hEE, 0, 0); doOp(1, 1, 3'd4, 8'hEE, 0, 0);
    doOp(1, 0, 3'd6, 0, 0, 0); check("R1", rdData, 0);
    rdDat(); check("R1", rdData, mBank[5]);

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [2:0] o;
      k = $urandom_range(0, 9);
      o = (k < 4) ? 3'd7 : (k < 8) ? 3'd3 : 3'($urandom_range(0, 7));
      if (o == 3'd3 && $urandom_range(0, 3) != 0 && $urandom_range(0, 1) == 1)
        o = 3'd7;
      doOp($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, o,
           ($urandom_range(0, 3) == 0) ? 8'(($urandom_range(0, 1) ? 23 : 1)) : 8'($urandom),
           $urandom_range(0, 7) == 0, 8'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule